// File: doc/BRIEF.md
# Two-Key Kick Unlock Guard

This block sits in front of a small bank of memory-mapped control registers and keeps software from changing them by accident. The bank is locked after reset. Software opens it by writing one fixed 32-bit key to a kick register at byte offset 0x38 and then a second fixed key to a kick register at byte offset 0x3C. Until both keys have arrived in that order, every write aimed at a bank register is thrown away and answered with a one-cycle error pulse. Reads are never held back.

The bank has two kinds of registers. Plain registers take every write made while the bank is open. Write-once registers record their first accepted write. After that, the bits selected by a mask parameter are frozen, and the other bits of that register stay writable. The block does not know what the registers control. It holds their values and exposes them through read data.

The bus is a simple single-cycle register port. It has a byte address, a write strobe, write data, combinational read data for the addressed word, and a registered write-error pulse. The two low address bits are ignored.

Top module: `kick_guard`

## Requirements
- R1: After reset the bank is locked, every bank register reads 0, no write-once register has been written, and the error output is low.
- R2: Writing KEY_A (default 0x83E70B13) to word 0x38 and then KEY_B (default 0x95A4F1E0) to word 0x3C opens the bank. The bank is still locked after the first key alone.
- R3: A write of any value other than the matching key to either kick register returns the guard to fully locked. The same holds for a write to 0x3C while fully locked, even with the right key. After any of these, KEY_B alone does not open the bank.
- R4: While the bank is open, a non-matching value written to 0x38 locks it again. KEY_A written to 0x38 or KEY_B written to 0x3C leaves it open.
- R5: A write to a bank register while the bank is not open (locked, or after the first key only) leaves the register unchanged. It raises the error output for exactly the next cycle, and does so once for each such write.
- R6: While the bank is open, a write to a plain register (word indexes 0 to N_PLAIN-1, byte offsets 0x00 up) stores the write data. The new value is visible on read data from the next cycle, and there is no error pulse.
- R7: Write-once registers follow the plain ones (default byte offsets 0x10 and 0x14). The first accepted write stores all bits. Later accepted writes change only the bits that are 0 in ONCE_MASK (default 0x0000FFFF, so bits 15:0 are frozen). A write dropped while the bank is locked does not count as the first write.
- R8: The kick registers read as 0. Addresses that map to no register (default 0x18 to 0x34, and beyond 0x3C) read as 0, and writes to them change nothing and raise no error.
- R9: Read data always shows the current contents of the addressed bank register, whether the bank is locked or open. Address bits 1:0 do not affect which register is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_we | input | 1 | Write strobe for this cycle |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Contents of the addressed word, combinational |
| reg_wr_err | output | 1 | High for one cycle after a dropped bank write |

## Verification
The bench builds the guard with its default parameters: four plain registers, two write-once registers, an 8-bit address and a mask that freezes the low half-word. With these values one run covers every address class: plain words, both write-once words, the unmapped gap between 0x18 and 0x34, and both kick words. The same mask also puts frozen and still-writable bits side by side in one register, so a single later write shows both behaviours. A random phase places correct and wrong keys in every lock state, and that reaches orderings that the directed sequence does not list.

// File: rtl/kick_guard_pkg.sv
package kick_guard_pkg;

    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_state_e;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_KICK_A = 2'd1,
        HIT_KICK_B = 2'd2,
        HIT_BANK   = 2'd3
    } addr_hit_e;

    // word indexes of the kick registers (byte offsets 0x38 and 0x3C)
    localparam int unsigned KICK_A_WORD = 14;
    localparam int unsigned KICK_B_WORD = 15;
    localparam int unsigned WORD_SHIFT  = 2;

endpackage

// File: rtl/kick_addr_decode.sv
module kick_addr_decode
    import kick_guard_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned N_PLAIN = 4,
    parameter int unsigned N_ONCE  = 2,
    localparam int unsigned N_REGS = N_PLAIN + N_ONCE,
    localparam int unsigned IDX_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output addr_hit_e         hit_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int unsigned WORD_W = ADDR_W - WORD_SHIFT;

    logic [WORD_W-1:0] word;

    always_comb begin
        word  = addr_i[ADDR_W-1:WORD_SHIFT];
        hit_o = HIT_NONE;
        idx_o = '0;
        if (word == WORD_W'(KICK_A_WORD)) begin
            hit_o = HIT_KICK_A;
        end else if (word == WORD_W'(KICK_B_WORD)) begin
            hit_o = HIT_KICK_B;
        end else if (32'(word) < N_REGS) begin
            hit_o = HIT_BANK;
            idx_o = IDX_W'(word);
        end
    end

endmodule

// File: rtl/kick_unlock_fsm.sv
module kick_unlock_fsm
    import kick_guard_pkg::*;
#(
    parameter int unsigned       DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_A  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_B  = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  addr_hit_e         hit_i,
    input  logic [DATA_W-1:0] wdata_i,
    output lock_state_e       state_o
);

    typedef struct packed {
        lock_state_e state;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (we_i) begin
            unique case (hit_i)
                HIT_KICK_A: begin
                    if (wdata_i == KEY_A) begin
                        // a good first key re-arms, but never closes an open bank
                        if (fsm_q.state != LK_OPEN) begin
                            fsm_d.state = LK_HALF;
                        end
                    end else begin
                        fsm_d.state = LK_CLOSED;
                    end
                end
                HIT_KICK_B: begin
                    if ((wdata_i == KEY_B) && (fsm_q.state != LK_CLOSED)) begin
                        fsm_d.state = LK_OPEN;
                    end else begin
                        fsm_d.state = LK_CLOSED;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= LK_CLOSED;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;

endmodule

// File: rtl/kick_reg_bank.sv
module kick_reg_bank #(
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       N_PLAIN   = 4,
    parameter int unsigned       N_ONCE    = 2,
    parameter logic [DATA_W-1:0] ONCE_MASK = 32'h0000_FFFF,
    localparam int unsigned      N_REGS    = N_PLAIN + N_ONCE,
    localparam int unsigned      IDX_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_stb_i,
    input  logic [IDX_W-1:0]               wr_idx_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [N_REGS-1:0][DATA_W-1:0]  vals_o
);

    typedef struct packed {
        logic [N_REGS-1:0][DATA_W-1:0] vals;
        logic [N_ONCE-1:0]             done;
    } bank_s;

    bank_s bank_d, bank_q;

    logic [DATA_W-1:0] val_nx  [N_REGS];
    logic              done_nx [N_ONCE];

    for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
        logic sel;
        assign sel        = wr_stb_i && (wr_idx_i == IDX_W'(gi));
        assign val_nx[gi] = sel ? wdata_i : bank_q.vals[gi];
    end

    for (genvar gj = 0; gj < N_ONCE; gj++) begin : g_once
        localparam int unsigned K = N_PLAIN + gj;
        logic              sel;
        logic [DATA_W-1:0] keep;
        assign sel         = wr_stb_i && (wr_idx_i == IDX_W'(K));
        assign keep        = bank_q.done[gj] ? ONCE_MASK : '0;
        assign val_nx[K]   = sel ? ((bank_q.vals[K] & keep) | (wdata_i & ~keep))
                                 : bank_q.vals[K];
        assign done_nx[gj] = bank_q.done[gj] | sel;
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < N_REGS; i++) begin
            bank_d.vals[i] = val_nx[i];
        end
        for (int j = 0; j < N_ONCE; j++) begin
            bank_d.done[j] = done_nx[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign vals_o = bank_q.vals;

endmodule

// File: rtl/kick_guard.sv
module kick_guard
    import kick_guard_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       N_PLAIN   = 4,
    parameter int unsigned       N_ONCE    = 2,
    parameter logic [DATA_W-1:0] ONCE_MASK = 32'h0000_FFFF,
    parameter logic [DATA_W-1:0] KEY_A     = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_B     = 32'h95A4_F1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr_err
);

    localparam int unsigned N_REGS = N_PLAIN + N_ONCE;
    localparam int unsigned IDX_W  = (N_REGS > 1) ? $clog2(N_REGS) : 1;

    typedef struct packed {
        logic wr_err;
    } top_s;

    addr_hit_e                     hit;
    logic [IDX_W-1:0]              bank_idx;
    lock_state_e                   lock_state;
    logic                          bank_wr;
    logic [N_REGS-1:0][DATA_W-1:0] bank_vals;
    top_s                          top_d, top_q;

    kick_addr_decode #(
        .ADDR_W  (ADDR_W),
        .N_PLAIN (N_PLAIN),
        .N_ONCE  (N_ONCE)
    ) u_decode (
        .addr_i (reg_addr),
        .hit_o  (hit),
        .idx_o  (bank_idx)
    );

    kick_unlock_fsm #(
        .DATA_W (DATA_W),
        .KEY_A  (KEY_A),
        .KEY_B  (KEY_B)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .hit_i   (hit),
        .wdata_i (reg_wdata),
        .state_o (lock_state)
    );

    kick_reg_bank #(
        .DATA_W    (DATA_W),
        .N_PLAIN   (N_PLAIN),
        .N_ONCE    (N_ONCE),
        .ONCE_MASK (ONCE_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (bank_wr),
        .wr_idx_i (bank_idx),
        .wdata_i  (reg_wdata),
        .vals_o   (bank_vals)
    );

    always_comb begin
        bank_wr      = reg_we && (hit == HIT_BANK) && (lock_state == LK_OPEN);
        top_d.wr_err = reg_we && (hit == HIT_BANK) && (lock_state != LK_OPEN);
        reg_rdata    = (hit == HIT_BANK) ? bank_vals[bank_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign reg_wr_err = top_q.wr_err;

endmodule

// File: rtl/kick_guard_chk.sv
module kick_guard_chk
    import kick_guard_pkg::*;
#(
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       N_PLAIN   = 4,
    parameter int unsigned       N_ONCE    = 2,
    parameter logic [DATA_W-1:0] ONCE_MASK = 32'h0000_FFFF,
    parameter logic [DATA_W-1:0] KEY_A     = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY_B     = 32'h95A4_F1E0,
    localparam int unsigned      N_REGS    = N_PLAIN + N_ONCE,
    localparam int unsigned      IDX_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          we,
    input addr_hit_e                     hit,
    input logic [IDX_W-1:0]              idx,
    input logic [DATA_W-1:0]             wdata,
    input lock_state_e                   state,
    input logic                          bank_wr,
    input logic                          wr_err,
    input logic [N_REGS-1:0][DATA_W-1:0] vals
);

    logic first_once_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_once_seen_q <= 1'b0;
        end else if (bank_wr && (idx == IDX_W'(N_PLAIN))) begin
            first_once_seen_q <= 1'b1;
        end
    end

    a_r5_locked_write_held: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (hit == HIT_BANK) && (state != LK_OPEN)) |=> $stable(vals));

    a_r5_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (hit == HIT_BANK) && (state != LK_OPEN)) |=> wr_err);

    a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(we && (hit == HIT_BANK) && (state != LK_OPEN)));

    a_r2_open_after_half: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == LK_OPEN) |-> $past(state == LK_HALF));

    a_r3_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (((hit == HIT_KICK_A) && (wdata != KEY_A)) ||
                ((hit == HIT_KICK_B) && (wdata != KEY_B))))
        |=> (state == LK_CLOSED));

    a_r8_non_bank_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || (hit != HIT_BANK)) |=> $stable(vals));

    a_r7_once_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        first_once_seen_q |=>
            ((vals[N_PLAIN] & ONCE_MASK) == $past(vals[N_PLAIN] & ONCE_MASK)));

endmodule

bind kick_guard kick_guard_chk #(
    .DATA_W    (DATA_W),
    .N_PLAIN   (N_PLAIN),
    .N_ONCE    (N_ONCE),
    .ONCE_MASK (ONCE_MASK),
    .KEY_A     (KEY_A),
    .KEY_B     (KEY_B)
) u_kick_guard_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .hit     (hit),
    .idx     (bank_idx),
    .wdata   (reg_wdata),
    .state   (lock_state),
    .bank_wr (bank_wr),
    .wr_err  (reg_wr_err),
    .vals    (bank_vals)
);

// File: tb/test_kick_guard.sv
module test_kick_guard;

    localparam logic [31:0] K_A  = 32'h83E7_0B13;
    localparam logic [31:0] K_B  = 32'h95A4_F1E0;
    localparam logic [31:0] MASK = 32'h0000_FFFF;
    localparam int NP = 4;
    localparam int NO = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_wr_err;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference
    logic [31:0] m_val [NP+NO];
    bit          m_done [NO];
    int          m_state = 0;   // 0 locked, 1 first key seen, 2 open
    bit          m_err = 1'b0;

    always #2.5ns clk = ~clk;

    kick_guard i_kick_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_wr_err (reg_wr_err)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int w = int'(a[7:2]);
        if (w < NP + NO) return m_val[w];
        return 32'h0;
    endfunction

    task automatic model_edge(input bit we, input logic [7:0] a, input logic [31:0] d);
        int w = int'(a[7:2]);
        m_err = 1'b0;
        if (!we) return;
        if (w == 14) begin
            if (d == K_A) begin
                if (m_state != 2) m_state = 1;
            end else begin
                m_state = 0;
            end
        end else if (w == 15) begin
            if (d == K_B && m_state != 0) m_state = 2;
            else m_state = 0;
        end else if (w < NP + NO) begin
            if (m_state == 2) begin
                if (w >= NP) begin
                    if (m_done[w-NP]) m_val[w] = (m_val[w] & MASK) | (d & ~MASK);
                    else m_val[w] = d;
                    m_done[w-NP] = 1'b1;
                end else begin
                    m_val[w] = d;
                end
            end else begin
                m_err = 1'b1;
            end
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                        input string tag);
        @(negedge clk);
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        model_edge(we, a, d);
        #1ns;
        check(tag, "rdata", reg_rdata, model_read(a));
        check(tag, "wr_err", {31'b0, reg_wr_err}, {31'b0, m_err});
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, tag);
    endtask

    task automatic unlock(input string tag);
        wr(8'h38, K_A, tag);
        wr(8'h3C, K_B, tag);
    endtask

    initial begin
        #(200000 * 5ns);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP + NO; i++) m_val[i] = '0;
        for (int j = 0; j < NO; j++) m_done[j] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R8: everything reads zero after reset, including kicks and gaps
        for (int a = 0; a < 64; a += 4) rd(8'(a), "R1");

        // R5: locked writes dropped, one pulse each, back to back
        wr(8'h00, 32'hDEAD_BEEF, "R5");
        wr(8'h04, 32'h1234_5678, "R5");
        rd(8'h00, "R5");
        rd(8'h04, "R5");

        // R3: second key first, wrong first key, wrong second key
        wr(8'h3C, K_B, "R3");
        wr(8'h00, 32'h0000_0001, "R3");
        wr(8'h38, 32'h0000_0000, "R3");
        wr(8'h3C, K_B, "R3");
        wr(8'h00, 32'h0000_0002, "R3");
        wr(8'h38, K_A, "R3");
        wr(8'h3C, 32'h95A4_F1E1, "R3");
        wr(8'h3C, K_B, "R3");
        wr(8'h08, 32'h0000_0003, "R3");

        // R2 / R5: first key alone keeps the bank closed
        wr(8'h38, K_A, "R2");
        wr(8'h0C, 32'hAAAA_0001, "R5");
        wr(8'h3C, K_B, "R2");

        // R6: plain writes land, no error
        wr(8'h00, 32'h1111_1111, "R6");
        wr(8'h04, 32'h2222_2222, "R6");
        wr(8'h08, 32'h3333_3333, "R6");
        wr(8'h0C, 32'h4444_4444, "R6");
        for (int a = 0; a < 16; a += 4) rd(8'(a), "R6");

        // R9: low address bits ignored
        rd(8'h05, "R9");
        rd(8'h0B, "R9");

        // R8: kicks read zero, gap writes do nothing
        rd(8'h38, "R8");
        rd(8'h3C, "R8");
        wr(8'h20, 32'hFFFF_FFFF, "R8");
        rd(8'h20, "R8");
        wr(8'h34, 32'hFFFF_FFFF, "R8");
        rd(8'h34, "R8");

        // R7: first write stores all bits, later ones only unmasked bits
        wr(8'h10, 32'hAAAA_5555, "R7");
        rd(8'h10, "R7");
        wr(8'h10, 32'h1234_5678, "R7");
        rd(8'h10, "R7");

        // R4: good keys keep open, bad first kick relocks
        wr(8'h38, K_A, "R4");
        wr(8'h00, 32'h5555_0000, "R4");
        wr(8'h3C, K_B, "R4");
        wr(8'h04, 32'h6666_0000, "R4");
        wr(8'h38, 32'h1111_1111, "R4");
        wr(8'h00, 32'h7777_7777, "R4");

        // R9: reads still work while locked
        for (int a = 0; a < 24; a += 4) rd(8'(a), "R9");

        // R7: dropped write does not consume the one write
        wr(8'h14, 32'hCAFE_F00D, "R7");
        unlock("R2");
        wr(8'h14, 32'h0BAD_BEEF, "R7");
        wr(8'h14, 32'hFFFF_FFFF, "R7");
        rd(8'h14, "R7");

        // random mix of keys and writes in every lock state
        for (int n = 0; n < 1500; n++) begin
            int unsigned pick = $urandom_range(0, 9);
            logic [7:0]  a;
            logic [31:0] d = $urandom;
            bit          we = ($urandom_range(0, 3) != 0);
            case (pick)
                0: a = 8'h38;
                1: a = 8'h3C;
                2: a = 8'h38;
                3: a = 8'h3C;
                4: a = 8'h24;
                default: a = 8'(($urandom_range(0, NP + NO - 1) * 4) + $urandom_range(0, 3));
            endcase
            if (a == 8'h38 && $urandom_range(0, 3) != 0) d = K_A;
            if (a == 8'h3C && $urandom_range(0, 3) != 0) d = K_B;
            step(we, a, d, "R3/R6 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule